// File: doc/BRIEF.md
# Receive Byte FIFO with Programmable Watermark

This block buffers the bytes that a serial bus controller receives, until software collects them. The bus engine offers one byte per cycle on a push strobe. Software reads the oldest byte by popping the data register. Software can read the fill level, which is reported zero-based: the reported value is the stored byte count minus one. The block also gives empty, full and overflow status flags.

Software programs a zero-based watermark. A value N means that a level-type "watermark reached" signal goes high while N+1 or more bytes are stored. A driver can then ask for an event after exactly the number of bytes it still expects. A flush input empties the FIFO when the controller is soft-reset. The flush leaves the watermark unchanged.

Top module: `rx_watermark_fifo`

## Requirements
- R1: After the synchronous reset the FIFO is empty (empty_o=1, full_o=0, occ_o=0), the watermark reads 0, overflow_o is 0 and rd_data_o is 0.
- R2: Bytes leave in the order they were accepted. A pop of a non-empty FIFO loads the oldest byte into rd_data_o, where it is visible from the cycle after the pop.
- R3: occ_o equals the stored byte count minus one, and reads 0 when the FIFO is empty. empty_o is 1 exactly when 0 bytes are stored. full_o is 1 exactly when 16 bytes are stored.
- R4: Writing N (4 bits, 0 to 15) with wm_we_i sets the watermark to N. wm_o reads it back from the next cycle.
- R5: wm_hit_o is a level, high in every cycle where the stored count is at least the watermark plus one, and low otherwise.
- R6: A pop while the FIFO is empty has no effect: rd_data_o keeps its last value and the count does not change.
- R7: A push while 16 bytes are stored and no pop is accepted is dropped: the stored bytes and the count are unchanged. The push also sets overflow_o, which stays 1 until a flush or a reset.
- R8: A push and a pop in the same cycle on a full FIFO are both accepted. The count stays at 16 and overflow_o does not change.
- R9: A flush empties the FIFO and clears overflow_o. It leaves the watermark and rd_data_o unchanged. A push or a pop in the same cycle as the flush has no effect, but a watermark write in that cycle still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Controller soft reset: empty the FIFO |
| push_valid_i | input | 1 | Bus engine offers a received byte |
| push_data_i | input | 8 | Received byte |
| pop_i | input | 1 | Data register read: remove the oldest byte |
| rd_data_o | output | 8 | Last byte popped |
| occ_o | output | 4 | Stored byte count minus one (0 when empty) |
| wm_we_i | input | 1 | Watermark write strobe |
| wm_data_i | input | 4 | Zero-based watermark value |
| wm_o | output | 4 | Current watermark |
| wm_hit_o | output | 1 | Stored count is at least the watermark plus one |
| empty_o | output | 1 | No byte stored |
| full_o | output | 1 | 16 bytes stored |
| overflow_o | output | 1 | Sticky: a push was dropped while full |

## Verification
The bench builds the block with its default depth of 16 and 8-bit data, so the full range of the 4-bit occupancy and watermark fields is exercised. Both watermark extremes are covered: 0 (fires on one byte) and 15 (fires only when full). Directed steps reach the full and empty corners, including a same-cycle push and pop on a full FIFO, a dropped push, a pop while empty and a flush that coincides with a push. A long random phase with occasional watermark writes and flushes then compares every output against a queue-based model in every cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned RXQ_DEPTH = 16;
    localparam int unsigned RXQ_DW    = 8;

    // Per-cycle decisions taken by the storage, consumed by the flag logic
    typedef struct packed {
        logic push_acc;
        logic pop_acc;
        logic push_drop;
    } rxq_ops_t;

    // Status bundle produced by the flag logic
    typedef struct packed {
        logic empty;
        logic full;
        logic wm_hit;
        logic overflow;
    } rxq_flags_t;

    // Threshold test: count reaches watermark plus one
    function automatic logic rxq_reached(input int unsigned count, input int unsigned wm);
        return count >= wm + 1;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    parameter int unsigned DW    = RXQ_DW,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic [DW-1:0] rd_data,
    output rxq_ops_t      ops
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          not_full;
    logic          not_empty;

    assign not_full  = (count != CW'(DEPTH));
    assign not_empty = (count != '0);

    always_comb begin
        ops.pop_acc   = pop && not_empty && !flush;
        ops.push_acc  = push_valid && !flush && (not_full || ops.pop_acc);
        ops.push_drop = push_valid && !flush && !ops.push_acc;
    end

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (ops.push_acc) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            rd_data <= '0;
        end else if (flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
        end else begin
            if (ops.push_acc) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (ops.pop_acc) begin
                rd_data <= mem[rd_ptr];
                rd_ptr  <= ptr_next(rd_ptr);
            end
            count <= count + CW'(ops.push_acc) - CW'(ops.pop_acc);
        end
    end

    // R3: the count never exceeds the capacity
    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R6: an idle pop on an empty FIFO changes neither count nor data
    p_pop_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (pop && count == '0 && !push_valid && !flush) |=>
            ($stable(rd_data) && count == '0));

    // R8: push and pop together on a full FIFO keep it full
    p_full_swap_r8: assert property (@(posedge clk) disable iff (rst)
        (push_valid && pop && !flush && count == CW'(DEPTH)) |=>
            (count == CW'(DEPTH)));

    // R9: a flush leaves the FIFO empty
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

endmodule

// File: rtl/rxq_wm.sv
module rxq_wm #(
    parameter int unsigned PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wm_we,
    input  logic [PW-1:0] wm_data,
    output logic [PW-1:0] wm
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wm <= '0;
        end else if (wm_we) begin
            wm <= wm_data;
        end
    end

    // R9: a flush without a write keeps the watermark
    p_wm_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (flush && !wm_we) |=> $stable(wm));

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [CW-1:0] count,
    input  logic [PW-1:0] wm,
    input  rxq_ops_t      ops,
    output logic [PW-1:0] occ,
    output rxq_flags_t    flags
);

    logic sticky_ovf;

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_ovf <= 1'b0;
        end else if (flush) begin
            sticky_ovf <= 1'b0;
        end else if (ops.push_drop) begin
            sticky_ovf <= 1'b1;
        end
    end

    always_comb begin
        occ            = (count == '0) ? '0 : PW'(count - CW'(1));
        flags.empty    = (count == '0);
        flags.full     = (count == CW'(DEPTH));
        flags.wm_hit   = rxq_reached(int'(count), int'(wm));
        flags.overflow = sticky_ovf;
    end

    // R3: empty and full are never both set
    p_empty_full_r3: assert property (@(posedge clk) disable iff (rst)
        !(flags.empty && flags.full));

    // R5: the watermark can never be reached with nothing stored
    p_hit_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        flags.wm_hit |-> !flags.empty);

    // R7: a dropped push raises the overflow flag
    p_drop_sets_r7: assert property (@(posedge clk) disable iff (rst)
        ops.push_drop |=> flags.overflow);

    // R7: the overflow flag stays set until flushed
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flags.overflow && !flush) |=> flags.overflow);

endmodule

// File: rtl/rx_watermark_fifo.sv
module rx_watermark_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    parameter int unsigned DW    = RXQ_DW,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush_i,
    input  logic          push_valid_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [DW-1:0] rd_data_o,
    output logic [PW-1:0] occ_o,
    input  logic          wm_we_i,
    input  logic [PW-1:0] wm_data_i,
    output logic [PW-1:0] wm_o,
    output logic          wm_hit_o,
    output logic          empty_o,
    output logic          full_o,
    output logic          overflow_o
);

    logic [CW-1:0] count;
    rxq_ops_t      ops;
    rxq_flags_t    flags;

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush_i),
        .push_valid (push_valid_i),
        .push_data  (push_data_i),
        .pop        (pop_i),
        .count      (count),
        .rd_data    (rd_data_o),
        .ops        (ops)
    );

    rxq_wm #(.PW(PW)) u_wm (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush_i),
        .wm_we   (wm_we_i),
        .wm_data (wm_data_i),
        .wm      (wm_o)
    );

    rxq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_i),
        .count (count),
        .wm    (wm_o),
        .ops   (ops),
        .occ   (occ_o),
        .flags (flags)
    );

    assign empty_o    = flags.empty;
    assign full_o     = flags.full;
    assign wm_hit_o   = flags.wm_hit;
    assign overflow_o = flags.overflow;

    // R2: a pop of a non-empty FIFO without flush leaves room afterwards
    p_pop_room_r2: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !empty_o && !flush_i && !push_valid_i) |=> !full_o);

endmodule

// File: tb/rx_watermark_fifo_tb.sv
module rx_watermark_fifo_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush_i = 1'b0;
    logic       push_valid_i = 1'b0;
    logic [7:0] push_data_i = '0;
    logic       pop_i = 1'b0;
    logic       wm_we_i = 1'b0;
    logic [3:0] wm_data_i = '0;
    logic [7:0] rd_data_o;
    logic [3:0] occ_o;
    logic [3:0] wm_o;
    logic       wm_hit_o;
    logic       empty_o;
    logic       full_o;
    logic       overflow_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit started = 0;

    always #5 clk = ~clk;

    rx_watermark_fifo u_dut (
        .clk(clk), .rst(rst), .flush_i(flush_i),
        .push_valid_i(push_valid_i), .push_data_i(push_data_i),
        .pop_i(pop_i), .rd_data_o(rd_data_o), .occ_o(occ_o),
        .wm_we_i(wm_we_i), .wm_data_i(wm_data_i), .wm_o(wm_o),
        .wm_hit_o(wm_hit_o), .empty_o(empty_o), .full_o(full_o),
        .overflow_o(overflow_o)
    );

    // Behavioural reference model
    byte unsigned q[$];
    int  m_rd  = 0;
    int  m_wm  = 0;
    bit  m_ovf = 0;

    always @(posedge clk) begin
        bit pop_ok;
        started <= 1'b1;
        if (rst) begin
            q.delete();
            m_rd = 0; m_wm = 0; m_ovf = 0;
        end else begin
            if (wm_we_i) m_wm = int'(wm_data_i);
            if (flush_i) begin
                q.delete();
                m_ovf = 0;
            end else begin
                pop_ok = pop_i && q.size() > 0;
                if (pop_ok) m_rd = int'(q.pop_front());
                if (push_valid_i) begin
                    if (q.size() < 16) q.push_back(push_data_i);
                    else m_ovf = 1;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            int n;
            n = q.size();
            chk("R2", "rd_data", int'(rd_data_o), m_rd);
            chk("R3", "occ", int'(occ_o), (n == 0) ? 0 : n - 1);
            chk("R3", "empty", int'(empty_o), int'(n == 0));
            chk("R3", "full", int'(full_o), int'(n == 16));
            chk("R4", "wm", int'(wm_o), m_wm);
            chk("R5", "wm_hit", int'(wm_hit_o), int'(n >= m_wm + 1));
            chk("R7", "overflow", int'(overflow_o), int'(m_ovf));
        end
    end

    task automatic cyc(input bit ps, input byte unsigned d, input bit pp,
                       input bit we, input int wd, input bit fl);
        push_valid_i = ps;
        push_data_i  = d;
        pop_i        = pp;
        wm_we_i      = we;
        wm_data_i    = 4'(wd);
        flush_i      = fl;
        @(negedge clk);
        push_valid_i = 0; pop_i = 0; wm_we_i = 0; flush_i = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "empty", int'(empty_o), 1);
        chk("R1", "occ", int'(occ_o), 0);
        chk("R1", "wm", int'(wm_o), 0);
        chk("R1", "overflow", int'(overflow_o), 0);
        chk("R1", "rd_data", int'(rd_data_o), 0);
        chk("R1", "full", int'(full_o), 0);

        // R4 watermark write
        cyc(0, 0, 0, 1, 3, 0);
        chk("R4", "wm after write", int'(wm_o), 3);

        // R5 threshold 4 bytes
        for (int i = 0; i < 3; i++) cyc(1, 8'h10 + 8'(i), 0, 0, 0, 0);
        chk("R3", "occ three bytes", int'(occ_o), 2);
        chk("R5", "hit at three", int'(wm_hit_o), 0);
        cyc(1, 8'h13, 0, 0, 0, 0);
        chk("R3", "occ four bytes", int'(occ_o), 3);
        chk("R5", "hit at four", int'(wm_hit_o), 1);

        // R2 ordering
        cyc(0, 0, 1, 0, 0, 0);
        chk("R2", "first pop", int'(rd_data_o), 8'h10);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R2", "second pop", int'(rd_data_o), 8'h11);
        chk("R5", "hit after pops", int'(wm_hit_o), 0);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R2", "fourth pop", int'(rd_data_o), 8'h13);
        chk("R3", "empty after drain", int'(empty_o), 1);

        // R6 pop while empty
        cyc(0, 0, 1, 0, 0, 0);
        chk("R6", "rd held", int'(rd_data_o), 8'h13);
        chk("R6", "still empty", int'(empty_o), 1);
        chk("R6", "occ", int'(occ_o), 0);

        // Fill to 16
        for (int i = 0; i < 16; i++) cyc(1, 8'h20 + 8'(i), 0, 0, 0, 0);
        chk("R3", "full flag", int'(full_o), 1);
        chk("R3", "occ full", int'(occ_o), 15);

        // R8 swap on full
        cyc(1, 8'h55, 1, 0, 0, 0);
        chk("R8", "rd oldest", int'(rd_data_o), 8'h20);
        chk("R8", "still full", int'(full_o), 1);
        chk("R8", "no overflow", int'(overflow_o), 0);

        // R7 dropped push
        cyc(1, 8'h66, 0, 0, 0, 0);
        chk("R7", "overflow set", int'(overflow_o), 1);
        chk("R7", "occ unchanged", int'(occ_o), 15);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R7", "content intact", int'(rd_data_o), 8'h21);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R7", "overflow sticky", int'(overflow_o), 1);

        // R5 maximum watermark
        cyc(0, 0, 0, 1, 15, 0);
        chk("R5", "hit at fifteen", int'(wm_hit_o), 0);
        cyc(1, 8'h77, 0, 0, 0, 0);
        chk("R5", "hit at sixteen", int'(wm_hit_o), 1);

        // R9 flush with a coinciding push and pop
        cyc(1, 8'h88, 1, 0, 0, 1);
        chk("R9", "empty", int'(empty_o), 1);
        chk("R9", "overflow cleared", int'(overflow_o), 0);
        chk("R9", "wm kept", int'(wm_o), 15);
        chk("R9", "rd kept", int'(rd_data_o), 8'h21);

        // R9 flush with watermark write
        cyc(0, 0, 0, 1, 2, 1);
        chk("R9", "wm written in flush", int'(wm_o), 2);

        // Random phase against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            cyc($urandom_range(0, 99) < 55, 8'($urandom), $urandom_range(0, 99) < 45,
                r < 4, int'($urandom_range(0, 15)), r == 50);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule